// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits on a 32-bit host write path and turns dword writes into whole-word updates for a bank of 128-bit control registers and a 64-bit-word SRAM. Each accepted dword lands in a holding register tagged with the base address of its wide word. The wide word is passed to the storage side only when every dword of that word has arrived, so no partial value ever reaches a register or SRAM word. Plain 32-bit registers skip the holding register and are forwarded directly.

Two descriptor-pointer registers get special treatment so that a host can update them without serialising against other wide writes. A write to the top dword of either one always produces a commit. Its lower 96 bits are zero unless the holding register already held the other three dwords of that same register. A lower-dword write to a descriptor register is dropped if the holding register is busy with another word. An optional legacy quirk lets a timer-command write on page 0 wipe the holding register.

Top module: `wide_write_collector`

## Requirements
- R1: A clock edge with `rst_n` low empties the holding register and drives `cm_strobe` low. Dwords collected before reset never complete a word after it.
- R2: A 128-bit register is any dword-aligned address with bit 23 clear whose page offset (address mod 0x2000) is not one of the special offsets. It commits once all four dwords of its 16-byte-aligned word are held. `cm_strobe` pulses in the cycle after the completing write. `cm_addr` is the 16-byte-aligned base and `cm_kind` is 1. Byte offset 4k of the word appears at `cm_data[32k+31:32k]`.
- R3: While fewer than all dwords of a wide word are held, no commit is issued.
- R4: Dwords of a wide word may arrive in any order; the write that completes the set causes the commit.
- R5: A write to a different wide word than the one held replaces the holding register contents with only the new dword. The dwords held before it are lost.
- R6: Addresses with bit 23 set select SRAM. An 8-byte-aligned word commits once both of its dwords are held, with `cm_kind` 2, `cm_addr` the 8-byte-aligned base, and `cm_data[127:64]` zero.
- R7: Special offsets are recognised on every page, where the page is the address divided by 0x2000.
- R8: Writes at page offsets 0x400 (event pointer) and 0x420 (timer command) commit in the next cycle with `cm_kind` 0, `cm_addr` equal to the write address, and the data zero-extended. Apart from R11, they leave the holding register untouched.
- R9: A write at page offset 0x83C or 0xA1C (top dword of the receive or transmit descriptor register at 0x830 or 0xA10) always commits in the next cycle with `cm_kind` 1 and `cm_addr` the register base. The write data goes to bits 127:96. Bits 95:0 carry the held dwords if all three lower dwords of that register were held, and are zero otherwise. The holding register is then empty.
- R10: A write to a lower dword of a descriptor register while the holding register holds dwords of a different word is discarded, and the holding register keeps its contents.
- R11: With `TMR_QUIRK` set, a timer-command write on page 0 empties the holding register. Timer-command writes on other pages do not.
- R12: After a wide commit the holding register is empty, and each commit is a one-cycle strobe caused by the write in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A dword write is presented this cycle |
| wr_addr | input | AW (24) | Byte address of the dword, low two bits ignored |
| wr_data | input | 32 | Dword write data |
| cm_strobe | output | 1 | One-cycle commit pulse toward storage |
| cm_addr | output | AW (24) | Base address of the committed word or narrow register |
| cm_data | output | 128 | Committed value, unused upper bits zero |
| cm_kind | output | 2 | 0 narrow register, 1 wide register, 2 SRAM word |

## Verification
Every result of this block is due exactly one clock after the write that triggers it: a narrow forward, a completing dword or a descriptor top dword is followed by a commit. The driver stamps each expected commit with the cycle number that follows the edge on which the write is captured. The monitor pops an item only when the cycle count reaches that stamp. It flags a missing strobe on the due cycle, and any strobe on a cycle with nothing due. Stimuli that must not commit (partial sets, dropped descriptor writes, collections wiped by reset or the quirk) are followed by idle cycles in which the absence of any strobe is counted as a check.

// File: rtl/wc_pkg.sv
// Shared types and fixed register offsets of the wide write collector.
// Assumes page offsets fit in the page-index width chosen at the top.
package wc_pkg;

    localparam int unsigned OFS_EVQ_PTR  = 'h400;
    localparam int unsigned OFS_TMR_CMD  = 'h420;
    localparam int unsigned OFS_RX_DESC  = 'h830;
    localparam int unsigned OFS_TX_DESC  = 'hA10;
    localparam int unsigned DWORDS       = 4;
    localparam int unsigned LANE_W       = $clog2(DWORDS);

    typedef enum logic [1:0] {
        KIND_NARROW = 2'd0,
        KIND_CSR    = 2'd1,
        KIND_SRAM   = 2'd2
    } wc_kind_e;

    typedef enum logic [1:0] {
        CLS_NARROW = 2'd0,
        CLS_CSR    = 2'd1,
        CLS_DESC   = 2'd2,
        CLS_SRAM   = 2'd3
    } wc_cls_e;

endpackage

// File: rtl/wc_decode.sv
// Address classifier: sorts a dword write into narrow, plain wide,
// descriptor or SRAM, and gives the wide-word base and dword lane.
// Assumes SRAM_SEL_BIT lies above the page-offset bits.
module wc_decode
    import wc_pkg::*;
#(
    parameter int AW           = 24,
    parameter int PAGE_BYTES   = 8192,
    parameter int SRAM_SEL_BIT = 23
) (
    input  logic [AW-1:0]     addr,
    output wc_cls_e           cls,
    output logic [AW-1:0]     base,
    output logic [LANE_W-1:0] lane,
    output logic              tmr_page0
);
    localparam int PB = $clog2(PAGE_BYTES);

    logic [PB-1:0] ofs;
    logic [PB-1:0] wide_ofs;
    logic          in_sram;

    assign ofs      = addr[PB-1:0];
    assign wide_ofs = {ofs[PB-1:4], 4'b0000};
    assign in_sram  = addr[SRAM_SEL_BIT];

    // Classify the address and derive base and lane.
    always_comb begin
        if (in_sram) begin
            cls  = CLS_SRAM;
            base = {addr[AW-1:3], 3'b000};
            lane = {1'b0, addr[2]};
        end else if (ofs == PB'(OFS_EVQ_PTR) || ofs == PB'(OFS_TMR_CMD)) begin
            cls  = CLS_NARROW;
            base = {addr[AW-1:2], 2'b00};
            lane = '0;
        end else begin
            base = {addr[AW-1:4], 4'b0000};
            lane = addr[3:2];
            if (wide_ofs == PB'(OFS_RX_DESC) || wide_ofs == PB'(OFS_TX_DESC))
                cls = CLS_DESC;
            else
                cls = CLS_CSR;
        end
    end

    // Timer command on the first page triggers the legacy wipe.
    assign tmr_page0 = !in_sram && (ofs == PB'(OFS_TMR_CMD)) && (addr[AW-1:PB] == '0);

endmodule

// File: rtl/wc_collector.sv
// Holding register with one valid bit per dword and a base-address tag.
// Decides per accepted write whether to store, drop or commit, and
// presents the commit request combinationally to the output stage.
module wc_collector
    import wc_pkg::*;
#(
    parameter int AW        = 24,
    parameter bit TMR_QUIRK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  wc_cls_e           cls,
    input  logic [AW-1:0]     base,
    input  logic [LANE_W-1:0] lane,
    input  logic              tmr_page0,
    input  logic [31:0]       wdata,
    output logic              commit_req,
    output logic [AW-1:0]     commit_addr,
    output logic [127:0]      commit_data,
    output wc_kind_e          commit_kind,
    output logic [DWORDS-1:0] coll_valid
);
    logic [DWORDS-1:0] valid_q, nxt_valid, mv, need, lane_we, lane_bit;
    logic [AW-1:0]     tag_q, nxt_tag;
    logic [31:0]       lane_q [DWORDS];
    logic [31:0]       merged [DWORDS];
    logic              same, do_store;

    assign lane_bit   = DWORDS'(1) << lane;
    assign same       = (|valid_q) && (tag_q == base);
    assign need       = (cls == CLS_SRAM) ? DWORDS'(3) : '1;
    assign mv         = (same ? valid_q : '0) | lane_bit;
    assign coll_valid = valid_q;

    // Per-lane storage: one dword register per lane.
    for (genvar k = 0; k < DWORDS; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (lane_we[k]) lane_q[k] <= wdata;
        end
        // Lane view as it would be after this write.
        assign merged[k] = lane_bit[k] ? wdata :
                           ((same && valid_q[k]) ? lane_q[k] : 32'h0);
    end

    // Store, drop or commit decision for the write this cycle.
    always_comb begin
        nxt_valid   = valid_q;
        nxt_tag     = tag_q;
        lane_we     = '0;
        do_store    = 1'b0;
        commit_req  = 1'b0;
        commit_addr = base;
        commit_kind = KIND_CSR;
        commit_data = '0;
        if (acc) begin
            unique case (cls)
                CLS_NARROW: begin
                    commit_req  = 1'b1;
                    commit_kind = KIND_NARROW;
                    commit_data = {96'b0, wdata};
                    if (TMR_QUIRK && tmr_page0) nxt_valid = '0;
                end
                CLS_DESC: begin
                    if (lane == LANE_W'(DWORDS - 1)) begin
                        commit_req = 1'b1;
                        if (same && (&valid_q[DWORDS-2:0]))
                            commit_data = {wdata, merged[2], merged[1], merged[0]};
                        else
                            commit_data = {wdata, 96'b0};
                        nxt_valid = '0;
                    end else if (!((|valid_q) && !same)) begin
                        do_store = 1'b1;
                    end
                end
                default: do_store = 1'b1;
            endcase
        end
        if (do_store) begin
            lane_we = lane_bit;
            nxt_tag = base;
            if ((mv & need) == need) begin
                commit_req = 1'b1;
                nxt_valid  = '0;
                if (cls == CLS_SRAM) begin
                    commit_kind = KIND_SRAM;
                    commit_data = {64'b0, merged[1], merged[0]};
                end else begin
                    commit_data = {merged[3], merged[2], merged[1], merged[0]};
                end
            end else begin
                nxt_valid = mv;
            end
        end
    end

    // Valid bits and tag update, emptied by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
        end else begin
            valid_q <= nxt_valid;
            tag_q   <= nxt_tag;
        end
    end

endmodule

// File: rtl/wc_commit_reg.sv
// Output stage: registers the commit request into a one-cycle strobe
// with address, data and kind held until the next commit.
module wc_commit_reg
    import wc_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] req_addr,
    input  logic [127:0]  req_data,
    input  wc_kind_e      req_kind,
    output logic          strobe,
    output logic [AW-1:0] addr,
    output logic [127:0]  data,
    output logic [1:0]    kind
);
    // Capture a commit request and pulse the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            addr   <= '0;
            data   <= '0;
            kind   <= '0;
        end else begin
            strobe <= req;
            if (req) begin
                addr <= req_addr;
                data <= req_data;
                kind <= req_kind;
            end
        end
    end

endmodule

// File: rtl/wide_write_collector.sv
// Top of the wide write collector: decode, holding register and
// commit stage. Assumes one dword write per cycle and an always-ready
// storage side.
module wide_write_collector
    import wc_pkg::*;
#(
    parameter int AW           = 24,
    parameter int PAGE_BYTES   = 8192,
    parameter int SRAM_SEL_BIT = 23,
    parameter bit TMR_QUIRK    = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    output logic          cm_strobe,
    output logic [AW-1:0] cm_addr,
    output logic [127:0]  cm_data,
    output logic [1:0]    cm_kind
);
    wc_cls_e           cls;
    logic [AW-1:0]     base;
    logic [LANE_W-1:0] lane;
    logic              tmr_page0;
    logic              req;
    logic [AW-1:0]     req_addr;
    logic [127:0]      req_data;
    wc_kind_e          req_kind;
    logic [DWORDS-1:0] coll_valid;

    wc_decode #(
        .AW(AW), .PAGE_BYTES(PAGE_BYTES), .SRAM_SEL_BIT(SRAM_SEL_BIT)
    ) u_decode (
        .addr(wr_addr), .cls(cls), .base(base), .lane(lane), .tmr_page0(tmr_page0)
    );

    wc_collector #(
        .AW(AW), .TMR_QUIRK(TMR_QUIRK)
    ) u_coll (
        .clk(clk), .rst_n(rst_n), .acc(wr_valid), .cls(cls), .base(base),
        .lane(lane), .tmr_page0(tmr_page0), .wdata(wr_data),
        .commit_req(req), .commit_addr(req_addr), .commit_data(req_data),
        .commit_kind(req_kind), .coll_valid(coll_valid)
    );

    wc_commit_reg #(
        .AW(AW)
    ) u_commit (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .req_data(req_data), .req_kind(req_kind), .strobe(cm_strobe),
        .addr(cm_addr), .data(cm_data), .kind(cm_kind)
    );

endmodule

// File: rtl/wc_checker.sv
// Property checker for the wide write collector, bound to the top.
// Recomputes address classes from the ports only.
module wc_checker #(
    parameter int AW           = 24,
    parameter int PAGE_BYTES   = 8192,
    parameter int SRAM_SEL_BIT = 23
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic [31:0]   wr_data,
    input logic          cm_strobe,
    input logic [AW-1:0] cm_addr,
    input logic [127:0]  cm_data,
    input logic [1:0]    cm_kind,
    input logic [3:0]    coll_valid
);
    localparam int PB = $clog2(PAGE_BYTES);

    logic [PB-1:0] pofs;
    logic          is_narrow, is_desc_top;

    assign pofs        = wr_addr[PB-1:0];
    assign is_narrow   = !wr_addr[SRAM_SEL_BIT] && (pofs == PB'('h400) || pofs == PB'('h420));
    assign is_desc_top = !wr_addr[SRAM_SEL_BIT] && (pofs[PB-1:2] == PB'('h83C) >> 2 ||
                                                    pofs[PB-1:2] == PB'('hA1C) >> 2);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !cm_strobe && coll_valid == 4'b0); // R1

    AST_CSR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cm_strobe && cm_kind == 2'd1 |-> cm_addr[3:0] == 4'h0); // R2

    AST_SRAM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cm_strobe && cm_kind == 2'd2 |-> cm_data[127:64] == 64'h0 && cm_addr[2:0] == 3'h0); // R6

    AST_NARROW_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && is_narrow |=> cm_strobe && cm_kind == 2'd0 &&
        cm_addr == $past(wr_addr) && cm_data == {96'b0, $past(wr_data)}); // R8

    AST_DESC_TOP_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && is_desc_top |=> cm_strobe && cm_kind == 2'd1 &&
        cm_data[127:96] == $past(wr_data) && coll_valid == 4'b0); // R9

    AST_EMPTY_AFTER_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        cm_strobe && cm_kind != 2'd0 |-> coll_valid == 4'b0); // R12

    AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cm_strobe |-> $past(wr_valid)); // R12

endmodule

bind wide_write_collector wc_checker #(
    .AW(AW), .PAGE_BYTES(PAGE_BYTES), .SRAM_SEL_BIT(SRAM_SEL_BIT)
) u_wc_checker (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .cm_strobe(cm_strobe), .cm_addr(cm_addr),
    .cm_data(cm_data), .cm_kind(cm_kind), .coll_valid(coll_valid)
);

// File: tb/test_wide_write_collector.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected commits stamped with
// their due cycle; a monitor compares them on the falling edge.
module test_wide_write_collector;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic [23:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         cm_strobe;
    logic [23:0]  cm_addr;
    logic [127:0] cm_data;
    logic [1:0]   cm_kind;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;
    int n_unexp = 0;

    typedef struct {
        int           due;
        logic [23:0]  a;
        logic [127:0] d;
        logic [1:0]   k;
        string        tag;
    } exp_t;
    exp_t sb[$];

    wide_write_collector i_wide_write_collector (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .cm_strobe(cm_strobe), .cm_addr(cm_addr),
        .cm_data(cm_data), .cm_kind(cm_kind)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop the item due this cycle, or flag a stray strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (!cm_strobe || cm_addr !== e.a || cm_data !== e.d || cm_kind !== e.k) begin
                    n_fails++;
                    $display("FAIL %s: got strobe=%0b addr=%h kind=%0d data=%h, expected strobe=1 addr=%h kind=%0d data=%h",
                             e.tag, cm_strobe, cm_addr, cm_kind, cm_data, e.a, e.k, e.d);
                end
            end else if (cm_strobe) begin
                n_unexp++;
                n_checks++;
                n_fails++;
                $display("FAIL R12 unexpected commit: got addr=%h kind=%0d data=%h, expected no strobe",
                         cm_addr, cm_kind, cm_data);
            end
        end
    end

    task automatic wr(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
    endtask

    task automatic wr_exp(input logic [23:0] a, input logic [31:0] d, input logic [23:0] ea,
                          input logic [127:0] ed, input logic [1:0] ek, input string tag);
        exp_t e;
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        e.due = cyc + 1;
        e.a = ea;
        e.d = ed;
        e.k = ek;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_valid = 1'b0;
        end
    endtask

    // No strobe may appear in the next few cycles.
    task automatic quiet(input string tag);
        int snap;
        snap = n_unexp;
        idle(4);
        n_checks++;
        if (n_unexp != snap || sb.size() != 0) begin
            n_fails++;
            $display("FAIL %s: got %0d stray commits, expected 0", tag, n_unexp - snap);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if (cm_strobe !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 reset: got strobe=%0b, expected 0", cm_strobe);
        end
        rst_n = 1'b1;
        idle(2);

        // R2, R3: in-order 128-bit word, quiet before the last dword
        wr(24'h000100, 32'h11110000);
        wr(24'h000104, 32'h11110001);
        wr(24'h000108, 32'h11110002);
        quiet("R3 three of four dwords");
        wr_exp(24'h00010C, 32'h11110003, 24'h000100,
               {32'h11110003, 32'h11110002, 32'h11110001, 32'h11110000}, 2'd1, "R2 full word");
        idle(2);

        // R12: a single dword after a commit does not commit
        wr(24'h00010C, 32'hDEAD0003);
        quiet("R12 empty after commit");

        // R4: out-of-order arrival on page 1
        wr(24'h00220C, 32'h22220003);
        wr(24'h002204, 32'h22220001);
        wr(24'h002200, 32'h22220000);
        wr_exp(24'h002208, 32'h22220002, 24'h002200,
               {32'h22220003, 32'h22220002, 32'h22220001, 32'h22220000}, 2'd1, "R4 any order");
        idle(2);

        // R5: a different word replaces the held one
        wr(24'h000300, 32'h33330000);
        wr(24'h000304, 32'h33330001);
        wr(24'h000310, 32'h44440000);
        wr(24'h000314, 32'h44440001);
        wr(24'h000318, 32'h44440002);
        wr_exp(24'h00031C, 32'h44440003, 24'h000310,
               {32'h44440003, 32'h44440002, 32'h44440001, 32'h44440000}, 2'd1, "R5 new word commits");
        wr(24'h000308, 32'h33330002);
        wr(24'h00030C, 32'h33330003);
        quiet("R5 replaced dwords lost");

        // R6: SRAM word, high dword first
        wr(24'h80000C, 32'h55550001);
        wr_exp(24'h800008, 32'h55550000, 24'h800008,
               {64'h0, 32'h55550001, 32'h55550000}, 2'd2, "R6 SRAM word");
        idle(2);

        // R7, R8, R11: narrow writes on other pages keep the held word
        wr(24'h000500, 32'h66660000);
        wr(24'h000504, 32'h66660001);
        wr(24'h000508, 32'h66660002);
        wr_exp(24'h004400, 32'hA0A0A0A0, 24'h004400, {96'h0, 32'hA0A0A0A0}, 2'd0, "R8 event pointer page 2");
        wr_exp(24'h006420, 32'hB0B0B0B0, 24'h006420, {96'h0, 32'hB0B0B0B0}, 2'd0, "R11 timer page 3");
        wr_exp(24'h00050C, 32'h66660003, 24'h000500,
               {32'h66660003, 32'h66660002, 32'h66660001, 32'h66660000}, 2'd1, "R8 held word survives");
        // R8: back-to-back narrow commits
        wr_exp(24'h000400, 32'h00000001, 24'h000400, {96'h0, 32'h00000001}, 2'd0, "R8 back to back 1");
        wr_exp(24'h002400, 32'h00000002, 24'h002400, {96'h0, 32'h00000002}, 2'd0, "R8 back to back 2");
        idle(2);

        // R11: timer command on page 0 wipes the holding register
        wr(24'h000600, 32'h77770000);
        wr(24'h000604, 32'h77770001);
        wr(24'h000608, 32'h77770002);
        wr_exp(24'h000420, 32'hC0C0C0C0, 24'h000420, {96'h0, 32'hC0C0C0C0}, 2'd0, "R11 timer page 0");
        wr(24'h00060C, 32'h77770003);
        quiet("R11 wiped collection");

        // R9, R7: descriptor top dword alone on page 1
        wr_exp(24'h002A1C, 32'h88880003, 24'h002A10, {32'h88880003, 96'h0}, 2'd1, "R9 top alone");
        idle(2);
        // R9: full descriptor
        wr(24'h000830, 32'h99990000);
        wr(24'h000834, 32'h99990001);
        wr(24'h000838, 32'h99990002);
        wr_exp(24'h00083C, 32'h99990003, 24'h000830,
               {32'h99990003, 32'h99990002, 32'h99990001, 32'h99990000}, 2'd1, "R9 full descriptor");
        idle(2);
        // R9: partial descriptor, low bits zero
        wr(24'h004830, 32'hAAAA0000);
        wr(24'h004838, 32'hAAAA0002);
        wr_exp(24'h00483C, 32'hAAAA0003, 24'h004830, {32'hAAAA0003, 96'h0}, 2'd1, "R9 partial zero fill");
        idle(2);

        // R10: conflicting lower descriptor dword is dropped
        wr(24'h000700, 32'hBBBB0000);
        wr(24'h000704, 32'hBBBB0001);
        wr(24'h000708, 32'hBBBB0002);
        wr(24'h000A14, 32'hEEEE0001);
        wr_exp(24'h00070C, 32'hBBBB0003, 24'h000700,
               {32'hBBBB0003, 32'hBBBB0002, 32'hBBBB0001, 32'hBBBB0000}, 2'd1, "R10 held word kept");
        idle(2);

        // R1: reset in the middle of a collection
        wr(24'h000900, 32'hCCCC0000);
        wr(24'h000904, 32'hCCCC0001);
        @(negedge clk);
        wr_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wr(24'h000908, 32'hCCCC0002);
        wr(24'h00090C, 32'hCCCC0003);
        quiet("R1 reset drops collection");

        idle(3);
        finish_run();
    end

endmodule